// File: doc/BRIEF.md
# Power-Fail Reset Supervisor

This block sequences the system reset around supply loss. An external comparator reports that the main supply is out of tolerance. The supervisor then pulls the reset output low and raises a write-protect signal that denies every register access. When the supply recovers, write protection drops at once. Reset stays asserted for a fixed recovery interval that is measured in ticks of the 32.768 kHz time base. The default interval is 8192 ticks, which is a quarter second.

The recovery interval can be extended. This happens when the oscillator was switched off while the part ran from backup power. In that case the interval does not start counting until an oscillator-stable input reports that the time base is running again. A new supply failure at any point during recovery sends the sequence back to the failed state, and the full interval is counted again afterwards.

The block also selects the power source. A second comparator reports whether the main supply is below the backup voltage. The block switches to backup only when the main supply is below both the power-fail threshold and the backup voltage, that is, below the lower of the two. All comparator inputs are asynchronous and pass through synchronizer stages before any logic uses them.

Top module: `pfs_supervisor`

## Requirements
- R1: While `rst_n` is low, and after its release until recovery finishes, `rst_pull_low` is 1 and `on_backup` is 0. `wr_protect` is 1 during `rst_n` low and for the two cycles after release.
- R2: A level of `pwr_fail` held high is seen as `rst_pull_low` = 1 at the third rising clock edge after it is applied, from any state, and not at the second.
- R3: `wr_protect` is 1 exactly while the synchronized failure is present. While it is 1, `acc_grant` is 0 whatever `acc_req` is. Otherwise `acc_grant` follows `acc_req`, and `wr_protect` = 1 always comes with `rst_pull_low` = 1.
- R4: Without extension, `rst_pull_low` falls at the clock edge that samples the HOLD_TICKS-th `tick` pulse. Counting starts with the pulse sampled at the fourth edge after `pwr_fail` is removed.
- R5: With extension, no `tick` counts toward the interval until `osc_stable` has been sampled high. Counting starts with the edge after that sample.
- R6: A `pwr_fail` that arrives during the recovery interval returns the block to the failed state. After `pwr_fail` clears, a full HOLD_TICKS interval is counted again.
- R7: `on_backup` becomes 1 at the third edge after both `vcc_lt_pf` and `vcc_lt_bat` are high. It is 0 at the third edge after either of them is low.
- R8: Extension applies only if `osc_off_cfg` was 1 during a failed-state cycle in which `on_backup` was 1. With `osc_off_cfg` = 1 but no switch to backup, the recovery interval is not extended.
- R9: Only cycles with `tick` = 1 advance the recovery interval. The interval is a count of ticks and does not depend on the system clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low logic reset (power-on) |
| tick | input | 1 | One-cycle pulse per period of the 32.768 kHz time base |
| pwr_fail | input | 1 | Asynchronous: main supply below the power-fail threshold |
| vcc_lt_pf | input | 1 | Asynchronous: main supply below the power-fail threshold (source-select comparator) |
| vcc_lt_bat | input | 1 | Asynchronous: main supply below the backup voltage |
| osc_off_cfg | input | 1 | Configuration: oscillator disabled while on backup |
| osc_stable | input | 1 | Oscillator has restarted and is stable |
| acc_req | input | 1 | Register access request from the serial interface |
| acc_grant | output | 1 | Access permitted |
| wr_protect | output | 1 | Register access blocked |
| rst_pull_low | output | 1 | Enable of the open-drain reset driver; 1 pulls reset low |
| on_backup | output | 1 | 1 selects backup power |

## Verification
The checker applies its rules on every cycle. A persistent failure must force reset and deny access. Write protection never appears without reset. Reset is released only on a tick edge. The interval counter stays at zero while the block waits for the oscillator. A main supply above the backup voltage never selects backup. The bench scenarios are needed for the rest: the exact number of ticks before release, the ticks skipped while the oscillator restarts, the restart of the interval after a failure in mid-recovery, and the condition that decides whether extension applies. All of these depend on tick counts across a whole sequence.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef enum logic [1:0] {
      S_FAILED   = 2'd0,
      S_OSC_WAIT = 2'd1,
      S_HOLD     = 2'd2,
      S_RUN      = 2'd3
   } pfs_state_e;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pfs_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[i] <= RST_VAL;
         end else if (i == 0) begin
            chain[i] <= d;
         end else begin
            chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pfs_hold_timer.sv
module pfs_hold_timer #(
   parameter int HOLD_TICKS = 8192,
   localparam int CNT_W     = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   output logic [CNT_W-1:0] count,
   output logic             done
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

   if (HOLD_TICKS < 2) begin : g_bad_ticks
      $error("pfs_hold_timer: HOLD_TICKS must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear || done) begin
         count <= '0;
      end else if (en) begin
         count <= count + 1'b1;
      end
   end

   assign done = en && !clear && (count == LAST);
endmodule

// File: rtl/pfs_power_sel.sv
module pfs_power_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic below_pf,
   input  logic below_bat,
   output logic use_backup
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         use_backup <= 1'b0;
      end else begin
         use_backup <= below_pf & below_bat;
      end
   end
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor #(
   parameter int HOLD_TICKS  = 8192,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pwr_fail,
   input  logic vcc_lt_pf,
   input  logic vcc_lt_bat,
   input  logic osc_off_cfg,
   input  logic osc_stable,
   input  logic acc_req,
   output logic acc_grant,
   output logic wr_protect,
   output logic rst_pull_low,
   output logic on_backup
);
   import pfs_pkg::*;

   localparam int CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;

   logic             fail_s;
   logic [1:0]       cmp_s;
   pfs_state_e       state, state_d;
   logic             ext_q, ext_d;
   logic             timer_clear, timer_en, timer_done;
   logic [CNT_W-1:0] hold_cnt;

   pfs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_fail_sync (
      .clk(clk), .rst_n(rst_n), .d(pwr_fail), .q(fail_s));

   pfs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_cmp_sync (
      .clk(clk), .rst_n(rst_n), .d({vcc_lt_bat, vcc_lt_pf}), .q(cmp_s));

   pfs_power_sel u_psel (
      .clk(clk), .rst_n(rst_n), .below_pf(cmp_s[0]), .below_bat(cmp_s[1]),
      .use_backup(on_backup));

   pfs_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(timer_clear), .en(timer_en),
      .count(hold_cnt), .done(timer_done));

   assign timer_clear = (state != S_HOLD) || fail_s;
   assign timer_en    = (state == S_HOLD) && tick;

   always_comb begin
      ext_d   = ext_q;
      state_d = state;
      case (state)
         S_FAILED: begin
            ext_d = ext_q | (osc_off_cfg & on_backup);
            if (!fail_s) state_d = ext_d ? S_OSC_WAIT : S_HOLD;
         end
         S_OSC_WAIT: begin
            if (fail_s)          state_d = S_FAILED;
            else if (osc_stable) state_d = S_HOLD;
         end
         S_HOLD: begin
            if (fail_s)          state_d = S_FAILED;
            else if (timer_done) state_d = S_RUN;
         end
         default: begin
            ext_d = 1'b0;
            if (fail_s) state_d = S_FAILED;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_FAILED;
         ext_q <= 1'b0;
      end else begin
         state <= state_d;
         ext_q <= ext_d;
      end
   end

   assign wr_protect   = (state == S_FAILED);
   assign rst_pull_low = (state != S_RUN);
   assign acc_grant    = acc_req & ~wr_protect;
endmodule

// File: rtl/pfs_supervisor_chk.sv
module pfs_supervisor_chk #(
   parameter int CNT_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             pwr_fail,
   input logic             vcc_lt_bat,
   input logic             acc_grant,
   input logic             wr_protect,
   input logic             rst_pull_low,
   input logic             on_backup,
   input pfs_pkg::pfs_state_e state,
   input logic [CNT_W-1:0] hold_cnt
);
   import pfs_pkg::*;

   p_fail_forces_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail && $past(pwr_fail) && $past(pwr_fail, 2) |=> rst_pull_low);

   p_fail_denies_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail && $past(pwr_fail) && $past(pwr_fail, 2) |=> !acc_grant);

   p_protect_with_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_protect |-> rst_pull_low);

   p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_pull_low) |-> $past(tick));

   p_no_count_in_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_OSC_WAIT) |-> (hold_cnt == '0));

   p_main_above_bat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !vcc_lt_bat && $past(!vcc_lt_bat) && $past(!vcc_lt_bat, 2) |=> !on_backup);
endmodule

bind pfs_supervisor pfs_supervisor_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_fail(pwr_fail),
   .vcc_lt_bat(vcc_lt_bat), .acc_grant(acc_grant), .wr_protect(wr_protect),
   .rst_pull_low(rst_pull_low), .on_backup(on_backup), .state(state),
   .hold_cnt(hold_cnt));

// File: tb/pfs_supervisor_tb.sv
module pfs_supervisor_tb;
   localparam int HOLD     = 32;
   localparam int TICK_DIV = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic pwr_fail = 1'b0, vcc_lt_pf = 1'b0, vcc_lt_bat = 1'b0;
   logic osc_off_cfg = 1'b0, osc_stable = 1'b1, acc_req = 1'b1;
   logic acc_grant, wr_protect, rst_pull_low, on_backup;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pfs_supervisor #(.HOLD_TICKS(HOLD), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_fail(pwr_fail),
      .vcc_lt_pf(vcc_lt_pf), .vcc_lt_bat(vcc_lt_bat), .osc_off_cfg(osc_off_cfg),
      .osc_stable(osc_stable), .acc_req(acc_req), .acc_grant(acc_grant),
      .wr_protect(wr_protect), .rst_pull_low(rst_pull_low), .on_backup(on_backup));

   initial begin
      int div = 0;
      forever begin
         @(posedge clk);
         #1;
         tick = (div == 0);
         div  = (div + 1) % TICK_DIV;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   // Called at the negedge where the failure inputs were just removed.
   task automatic measure_hold(input bit wait_osc, input int osc_delay, output int n);
      bit armed = !wait_osc;
      int cyc = 0;
      n = 0;
      edges(3);
      while (rst_pull_low && cyc < 5000) begin
         if (wait_osc && cyc == osc_delay) osc_stable = 1'b1;
         if (armed) n += int'(tick);
         if (osc_stable) armed = 1'b1;
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic t_reset_state;
      int n;
      @(negedge clk);
      chk(rst_pull_low == 1'b1, "R1 reset asserted", rst_pull_low, 1);
      chk(wr_protect == 1'b1, "R1 protect in reset", wr_protect, 1);
      chk(on_backup == 1'b0, "R1 main power in reset", on_backup, 0);
      chk(acc_grant == 1'b0, "R3 no grant in reset", acc_grant, 0);
      rst_n = 1'b1;
      measure_hold(1'b0, 0, n);
      chk(n == HOLD, "R1 power-up hold ticks", n, HOLD);
      chk(acc_grant == 1'b1, "R3 grant after recovery", acc_grant, 1);
   endtask

   task automatic t_fail_latency;
      int n;
      pwr_fail = 1'b1;
      edges(2);
      chk(rst_pull_low == 1'b0, "R2 not yet at second edge", rst_pull_low, 0);
      edges(1);
      chk(rst_pull_low == 1'b1, "R2 reset at third edge", rst_pull_low, 1);
      chk(wr_protect == 1'b1, "R3 protect during fail", wr_protect, 1);
      chk(acc_grant == 1'b0, "R3 access blocked", acc_grant, 0);
      edges(10);
      pwr_fail = 1'b0;
      measure_hold(1'b0, 0, n);
      chk(n == HOLD, "R4 hold ticks", n, HOLD);
      chk(rst_pull_low == 1'b0, "R4 released", rst_pull_low, 1'b0);
   endtask

   task automatic t_protect_drops;
      pwr_fail = 1'b1;
      edges(8);
      pwr_fail = 1'b0;
      edges(3);
      chk(wr_protect == 1'b0, "R3 protect drops with fail", wr_protect, 0);
      chk(rst_pull_low == 1'b1, "R4 reset still held", rst_pull_low, 1);
      acc_req = 1'b0;
      #1;
      chk(acc_grant == 1'b0, "R3 grant follows request", acc_grant, 0);
      acc_req = 1'b1;
      #1;
      chk(acc_grant == 1'b1, "R3 grant follows request", acc_grant, 1);
      while (rst_pull_low) @(negedge clk);
   endtask

   task automatic t_backup_select;
      vcc_lt_pf = 1'b1;
      edges(4);
      chk(on_backup == 1'b0, "R7 one comparator only", on_backup, 0);
      vcc_lt_bat = 1'b1;
      edges(2);
      chk(on_backup == 1'b0, "R7 not at second edge", on_backup, 0);
      edges(1);
      chk(on_backup == 1'b1, "R7 backup at third edge", on_backup, 1);
      vcc_lt_pf = 1'b0;
      edges(3);
      chk(on_backup == 1'b0, "R7 back to main", on_backup, 0);
      vcc_lt_bat = 1'b0;
      edges(2);
   endtask

   task automatic t_extension;
      int n;
      osc_off_cfg = 1'b1;
      osc_stable  = 1'b0;
      pwr_fail = 1'b1; vcc_lt_pf = 1'b1; vcc_lt_bat = 1'b1;
      edges(12);
      chk(on_backup == 1'b1, "R8 on backup in outage", on_backup, 1);
      pwr_fail = 1'b0; vcc_lt_pf = 1'b0; vcc_lt_bat = 1'b0;
      measure_hold(1'b1, 40, n);
      chk(n == HOLD, "R5 ticks after osc stable", n, HOLD);
      osc_off_cfg = 1'b0;
   endtask

   task automatic t_osc_never;
      pwr_fail = 1'b1; vcc_lt_pf = 1'b1; vcc_lt_bat = 1'b1;
      osc_off_cfg = 1'b1;
      osc_stable  = 1'b0;
      edges(10);
      pwr_fail = 1'b0; vcc_lt_pf = 1'b0; vcc_lt_bat = 1'b0;
      edges(3 + 3 * HOLD * TICK_DIV);
      chk(rst_pull_low == 1'b1, "R5 held while osc unstable", rst_pull_low, 1);
      osc_stable = 1'b1;
      while (rst_pull_low) @(negedge clk);
      osc_off_cfg = 1'b0;
   endtask

   task automatic t_no_ext_without_backup;
      int n;
      osc_off_cfg = 1'b1;
      osc_stable  = 1'b0;
      pwr_fail = 1'b1; vcc_lt_pf = 1'b1;
      edges(10);
      pwr_fail = 1'b0; vcc_lt_pf = 1'b0;
      measure_hold(1'b0, 0, n);
      chk(n == HOLD, "R8 no extension without backup", n, HOLD);
      osc_stable  = 1'b1;
      osc_off_cfg = 1'b0;
   endtask

   task automatic t_restart;
      int n;
      pwr_fail = 1'b1;
      edges(6);
      pwr_fail = 1'b0;
      edges(3 + (HOLD / 2) * TICK_DIV);
      chk(rst_pull_low == 1'b1, "R6 mid hold", rst_pull_low, 1);
      pwr_fail = 1'b1;
      edges(3);
      chk(wr_protect == 1'b1, "R6 back to failed state", wr_protect, 1);
      edges(4);
      pwr_fail = 1'b0;
      measure_hold(1'b0, 0, n);
      chk(n == HOLD, "R6 full interval again", n, HOLD);
   endtask

   task automatic t_tick_only;
      int cyc = 0;
      pwr_fail = 1'b1;
      edges(6);
      pwr_fail = 1'b0;
      edges(3);
      while (rst_pull_low && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
      // Release edge plus the 3 pipeline edges: interval spans HOLD tick periods.
      chk(cyc >= (HOLD - 1) * TICK_DIV && cyc <= HOLD * TICK_DIV,
          "R9 interval tracks tick rate", cyc, HOLD * TICK_DIV);
   endtask

   initial begin
      edges(3);
      t_reset_state();
      t_fail_latency();
      t_protect_drops();
      t_backup_select();
      t_extension();
      t_osc_never();
      t_no_ext_without_backup();
      t_restart();
      t_tick_only();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule